// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns an active-low external interrupt line into a latched request for a small processor core. The raw line is first brought into the core clock domain. Its synchronized level then feeds a falling-edge detector and a low-level detector. A mode input selects how the line triggers a request: either on falling edges only, or on falling edges and on a held low level. The held-low mode lets several open-drain sources share one wired-OR line, because the request persists as long as any one of them keeps the line low.

The core owns the handshake. On each instruction boundary it raises a strobe. The block answers in the same cycle with a take-interrupt signal, but only when a request is latched, the enable input is high and the global mask is clear. The core clears the latch through a vector-fetch strobe. A request that arrives during the service routine is therefore captured again. A request that is held back by the mask is taken at the first boundary after the mask clears.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset the latch is empty and `takeIrq` stays low at instruction boundaries while the line is high.
- R2: With `irqEnable`=1, a high-to-low transition of `pinRaw` sets the latch in either mode. The latch is visible at `takeIrq` after the third rising clock edge that follows the transition, and not after the second.
- R3: With `levelMode`=1 and `irqEnable`=1, a low line sets the latch on every cycle. A vector fetch while the line stays low therefore leaves the request present.
- R4: With `levelMode`=0, a line that stays low after a vector fetch does not set the latch again. A new request needs the line to go high and then low.
- R5: `takeIrq` is high exactly when `instrDone`, the latch, `irqEnable` and not-`maskBit` all hold. It is never high while `instrDone` is low.
- R6: While `maskBit`=1 or `irqEnable`=0, a latched request is kept. It is taken at the first instruction boundary after the block is unmasked and enabled.
- R7: A `vecFetch` pulse with no new trigger in that cycle empties the latch at the next clock edge.
- R8: When a trigger and a `vecFetch` fall in the same cycle, the latch ends up set.
- R9: While `irqEnable`=0, edges and low levels on the line do not set the latch.
- R10: The edge detector starts disarmed. A line held low through reset and after it produces no edge-mode request until it has been seen high.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinRaw | input | 1 | Raw active-low interrupt line, asynchronous |
| levelMode | input | 1 | 1: falling edge or low level triggers; 0: falling edge only |
| irqEnable | input | 1 | Line acts as interrupt input and requests may be taken |
| maskBit | input | 1 | Global interrupt mask of the core, 1 blocks taking |
| instrDone | input | 1 | Instruction-boundary strobe |
| vecFetch | input | 1 | Vector-fetch strobe, clears the latch |
| takeIrq | output | 1 | Begin the interrupt sequence this boundary |

## Verification
On every cycle the assertions check the following latch updates: a qualified edge or low level sets the latch, a vector fetch clears it when no trigger is present, the latch holds while disabled, and it stays empty when nothing triggers it. They also check that an edge pulse lasts one cycle and that `takeIrq` only appears at a boundary with the enable high and the mask clear. Several behaviours depend on the history of the line, so only the bench scenarios can show them. These are the exact three-edge latency through the synchronizer, re-arming in edge mode only after a high phase, the disarmed start when the line is low through reset, and a masked request that is taken once the mask drops.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  // Events seen on the synchronized line, datapath -> control
  typedef struct packed {
    logic fallEdge;
    logic lowLevel;
  } pinEvt_t;

  // Strobes from control to the request latch
  typedef struct packed {
    logic setReq;
    logic clrReq;
  } latchCmd_t;
endpackage

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pinRaw,
  input  latchCmd_t cmd,
  output pinEvt_t   evt,
  output logic      reqPending
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncSr;
  logic [LAST:0] primeSr;
  logic          pinLevel;
  logic          primed;
  logic          prevHigh;

  // Synchronizer chain and warm-up chain of equal depth
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncSr[i]  <= 1'b1;
          primeSr[i] <= 1'b0;
        end else begin
          syncSr[i]  <= pinRaw;
          primeSr[i] <= 1'b1;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncSr[i]  <= 1'b1;
          primeSr[i] <= 1'b0;
        end else begin
          syncSr[i]  <= syncSr[i-1];
          primeSr[i] <= primeSr[i-1];
        end
      end
    end
  end

  assign pinLevel = syncSr[LAST];
  assign primed   = primeSr[LAST];

  // Edge detector arms only on a genuine high sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevHigh <= 1'b0;
    else       prevHigh <= primed & pinLevel;
  end

  assign evt.fallEdge = prevHigh & ~pinLevel;
  assign evt.lowLevel = primed & ~pinLevel;

  // Request latch: set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           reqPending <= 1'b0;
    else if (cmd.setReq) reqPending <= 1'b1;
    else if (cmd.clrReq) reqPending <= 1'b0;
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
(
  input  pinEvt_t   evt,
  input  logic      levelMode,
  input  logic      irqEnable,
  input  logic      maskBit,
  input  logic      instrDone,
  input  logic      vecFetch,
  input  logic      reqPending,
  output latchCmd_t cmd,
  output logic      takeIrq
);
  logic trigger;

  always_comb begin
    trigger    = evt.fallEdge | (levelMode & evt.lowLevel);
    cmd.setReq = irqEnable & trigger;
    cmd.clrReq = vecFetch;
    takeIrq    = instrDone & reqPending & irqEnable & ~maskBit;
  end
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  input  logic levelMode,
  input  logic irqEnable,
  input  logic maskBit,
  input  logic instrDone,
  input  logic vecFetch,
  output logic takeIrq
);
  pinEvt_t   pinEvt;
  latchCmd_t latchCmd;
  logic      reqPending;
  logic      fallSeen;
  logic      lowSeen;

  ext_irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .pinRaw    (pinRaw),
    .cmd       (latchCmd),
    .evt       (pinEvt),
    .reqPending(reqPending)
  );

  ext_irq_ctrl ctrl_i (
    .evt       (pinEvt),
    .levelMode (levelMode),
    .irqEnable (irqEnable),
    .maskBit   (maskBit),
    .instrDone (instrDone),
    .vecFetch  (vecFetch),
    .reqPending(reqPending),
    .cmd       (latchCmd),
    .takeIrq   (takeIrq)
  );

  assign fallSeen = pinEvt.fallEdge;
  assign lowSeen  = pinEvt.lowLevel;
endmodule

// File: rtl/ext_irq_latch_chk.sv
module ext_irq_latch_chk (
  input logic clk,
  input logic rstN,
  input logic levelMode,
  input logic irqEnable,
  input logic maskBit,
  input logic instrDone,
  input logic vecFetch,
  input logic takeIrq,
  input logic reqPending,
  input logic fallSeen,
  input logic lowSeen
);
  logic trig;
  assign trig = irqEnable && (fallSeen || (levelMode && lowSeen));

  a_r5_take_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (instrDone && irqEnable && !maskBit && reqPending));

  a_r8_trigger_sets: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> reqPending);

  a_r3_level_holds: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable && levelMode && lowSeen && vecFetch) |=> reqPending);

  a_r7_fetch_clears: assert property (@(posedge clk) disable iff (!rstN)
    (vecFetch && !trig) |=> !reqPending);

  a_r9_disabled_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEnable && !vecFetch) |=> (reqPending == $past(reqPending)));

  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rstN)
    (!reqPending && !trig) |=> !reqPending);

  a_r2_edge_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    fallSeen |=> !fallSeen);
endmodule

bind ext_irq_latch ext_irq_latch_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .levelMode (levelMode),
  .irqEnable (irqEnable),
  .maskBit   (maskBit),
  .instrDone (instrDone),
  .vecFetch  (vecFetch),
  .takeIrq   (takeIrq),
  .reqPending(reqPending),
  .fallSeen  (fallSeen),
  .lowSeen   (lowSeen)
);

// File: tb/ext_irq_latch_tb_top.sv
`timescale 1ns/100ps
module ext_irq_latch_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinRaw = 1'b1;
  logic levelMode = 1'b0;
  logic irqEnable = 1'b1;
  logic maskBit = 1'b0;
  logic instrDone = 1'b0;
  logic vecFetch = 1'b0;
  logic takeIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_latch dut_i (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .levelMode(levelMode),
    .irqEnable(irqEnable), .maskBit(maskBit), .instrDone(instrDone),
    .vecFetch(vecFetch), .takeIrq(takeIrq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Observe the latch through takeIrq without letting an edge pass
  task automatic probe(input string req, input logic exp);
    logic sEn, sMk, sId;
    sEn = irqEnable; sMk = maskBit; sId = instrDone;
    irqEnable = 1'b1; maskBit = 1'b0; instrDone = 1'b1;
    #0.5;
    check(req, takeIrq, exp);
    irqEnable = sEn; maskBit = sMk; instrDone = sId;
  endtask

  task automatic clearLatch();
    vecFetch = 1'b1; tick(1); vecFetch = 1'b0;
  endtask

  task automatic pulseLow();
    pinRaw = 1'b0; tick(4); pinRaw = 1'b1; tick(4);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: line low through reset, edge mode
    pinRaw = 1'b0;
    tick(3); rstN = 1'b1; tick(10);
    probe("R10 no request from low line after reset", 1'b0);
    // R3: switching to level mode with line low requests
    levelMode = 1'b1; tick(1);
    probe("R3 level low sets latch", 1'b1);
    clearLatch();
    probe("R3 fetch while low keeps request", 1'b1);
    pinRaw = 1'b1; levelMode = 1'b0; tick(4); clearLatch();

    // R1: fresh reset with line high
    rstN = 1'b0; tick(2); rstN = 1'b1; tick(5);
    probe("R1 empty after reset", 1'b0);
    instrDone = 1'b1; #0.5;
    check("R1 takeIrq low after reset", takeIrq, 1'b0);
    instrDone = 1'b0;

    // R2: latency in both modes
    for (int m = 0; m < 2; m++) begin
      levelMode = m[0];
      tick(1);
      pinRaw = 1'b0;
      tick(2); probe("R2 not yet set after two edges", 1'b0);
      tick(1); probe("R2 set after third edge", 1'b1);
      pinRaw = 1'b1; tick(4); clearLatch();
      probe("R7 fetch empties latch", 1'b0);
    end

    // R4: edge-only, held low does not re-request
    levelMode = 1'b0;
    pinRaw = 1'b0; tick(4);
    clearLatch();
    tick(10);
    probe("R4 held low no re-request", 1'b0);
    pinRaw = 1'b1; tick(4); pinRaw = 1'b0; tick(3);
    probe("R4 high then low re-requests", 1'b1);
    pinRaw = 1'b1; tick(4); clearLatch();

    // R8: fetch in the same cycle as the edge
    pinRaw = 1'b0; tick(4); pinRaw = 1'b1; tick(4); // latch set
    pinRaw = 1'b0; tick(2);
    vecFetch = 1'b1; tick(1); vecFetch = 1'b0;
    probe("R8 set wins over same-cycle fetch", 1'b1);
    vecFetch = 1'b1; tick(1); vecFetch = 1'b0;
    probe("R7 later fetch clears", 1'b0);
    pinRaw = 1'b1; tick(4);

    // R9: disabled line activity is ignored, both modes
    for (int m = 0; m < 2; m++) begin
      levelMode = m[0];
      irqEnable = 1'b0;
      pinRaw = 1'b0; tick(6);
      probe("R9 disabled low ignored", 1'b0);
      pinRaw = 1'b1; tick(4);
      probe("R9 disabled edge ignored", 1'b0);
      irqEnable = 1'b1; tick(2);
    end

    // R5/R6: sweep mode, enable, mask with a pending request
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int k = 0; k < 2; k++) begin
          levelMode = m[0]; irqEnable = 1'b1; maskBit = 1'b0;
          pulseLow();
          irqEnable = e[0]; maskBit = k[0];
          tick(3);
          instrDone = 1'b0; #0.5;
          check("R5 no take without boundary", takeIrq, 1'b0);
          instrDone = 1'b1; #0.5;
          check("R5 take gated by enable and mask", takeIrq, e[0] & ~k[0]);
          instrDone = 1'b0;
          tick(1);
          irqEnable = 1'b1; maskBit = 1'b0; instrDone = 1'b1; #0.5;
          check("R6 request kept and taken after unmask", takeIrq, 1'b1);
          instrDone = 1'b0;
          clearLatch();
          probe("R7 cleared after service", 1'b0);
        end
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule